// File: doc/BRIEF.md
# Program Counter Sequencer with Fixed Vectors

This block holds the program counter of a single-cycle 32-bit processor and works out the next value it loads. Every rising clock edge it loads one of seven candidates, picked by a 3-bit source code from the control decode. The candidates are:

- the sequential address (current PC plus four);
- a PC-relative branch target, formed by a dedicated adder;
- a region-absolute jump target, built from a 26-bit field;
- a value read from the register file;
- three hard-wired vectors: power-up, bad opcode and interrupt.

The current PC goes to instruction memory. PC plus four is also brought out, so a link register can be written.

A synchronous active-low reset also forces the power-up vector, so the PC has a known value before the decode logic first drives the source code. The register has no hold or stall input, so it takes a new value on every edge.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC loads 0x80000000, whatever `sel` is.
- R2: `pc_plus4` always equals `pc` + 4 modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.
- R3: With `sel` = 0, the PC becomes the old PC + 4 at the edge.
- R4: With `sel` = 1, the PC becomes old PC + 4 + (`imm` sign-extended from bit 15, times four). An all-ones immediate gives old PC, and 0x8000 gives a step of -0x20000.
- R5: With `sel` = 2, the PC becomes {bits 31:28 of old PC + 4, `jfield`, 2'b00}. The upper four bits come from the incremented PC, not the old PC.
- R6: With `sel` = 3, the PC becomes `reg_val` exactly, including its two low bits.
- R7: `sel` = 4 loads 0x80000000, `sel` = 5 loads 0x80000040 and `sel` = 6 loads 0x80000080.
- R8: `sel` = 7 behaves like `sel` = 0.
- R9: The PC takes its selected next value at every rising edge out of reset. There is no hold condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset, loads the power-up vector |
| sel | input | 3 | Next-PC source code (0 sequential, 1 branch, 2 jump, 3 register, 4 power-up, 5 bad opcode, 6 interrupt, 7 sequential) |
| imm | input | 16 | Branch displacement in words, signed |
| jfield | input | 26 | Jump word index within the current 256 MB region |
| reg_val | input | 32 | Register-file value for indirect jumps |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus four |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit displacement, a 26-bit jump field and the three vector values. With these, a sign bit at bit 15 reaches the full upper half of the address. A jump issued from 0xEFFFFFFC shows the region bits taken from the incremented PC rather than the old one. Stepping past 0xFFFFFFFC shows the increment wrapping to zero. Reset is also applied mid-run with a register jump selected, to show that reset wins over `sel`.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [2:0] {
        SRC_SEQ     = 3'd0,
        SRC_BRANCH  = 3'd1,
        SRC_JUMP    = 3'd2,
        SRC_REG     = 3'd3,
        SRC_POWERUP = 3'd4,
        SRC_BADOP   = 3'd5,
        SRC_IRQ     = 3'd6,
        SRC_SPARE   = 3'd7
    } pc_src_e;

endpackage

// File: rtl/pc_target_gen.sv
module pc_target_gen #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int JF_W  = 26
) (
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [JF_W-1:0]  jfield,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  branch_pc,
    output logic [XLEN-1:0]  jump_pc
);
    localparam int ALIGN   = 2;
    localparam int EXT_W   = XLEN - IMM_W - ALIGN;
    localparam int UPPER_W = XLEN - JF_W - ALIGN;
    localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

    logic [XLEN-1:0] offset;

    // word displacement to byte offset: sign copy plus two zero wires
    assign offset    = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN{1'b0}}};
    assign seq_pc    = cur_pc + STEP;
    assign branch_pc = seq_pc + offset;

    generate
        if (UPPER_W > 0) begin : g_region
            assign jump_pc = {seq_pc[XLEN-1 -: UPPER_W], jfield, {ALIGN{1'b0}}};
        end else begin : g_flat
            assign jump_pc = {jfield[XLEN-ALIGN-1:0], {ALIGN{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
    import pcseq_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] POWERUP_VEC = 32'h8000_0000,
    parameter logic [XLEN-1:0] BADOP_VEC   = 32'h8000_0040,
    parameter logic [XLEN-1:0] IRQ_VEC     = 32'h8000_0080
) (
    input  logic [2:0]      sel,
    input  logic [XLEN-1:0] seq_pc,
    input  logic [XLEN-1:0] branch_pc,
    input  logic [XLEN-1:0] jump_pc,
    input  logic [XLEN-1:0] reg_val,
    output logic [XLEN-1:0] next_pc
);
    pc_src_e src;

    assign src = pc_src_e'(sel);

    always_comb begin
        unique case (src)
            SRC_SEQ:     next_pc = seq_pc;
            SRC_BRANCH:  next_pc = branch_pc;
            SRC_JUMP:    next_pc = jump_pc;
            SRC_REG:     next_pc = reg_val;
            SRC_POWERUP: next_pc = POWERUP_VEC;
            SRC_BADOP:   next_pc = BADOP_VEC;
            SRC_IRQ:     next_pc = IRQ_VEC;
            SRC_SPARE:   next_pc = seq_pc;
            default:     next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
    parameter int              XLEN        = 32,
    parameter int              IMM_W       = 16,
    parameter int              JF_W        = 26,
    parameter logic [XLEN-1:0] POWERUP_VEC = 32'h8000_0000,
    parameter logic [XLEN-1:0] BADOP_VEC   = 32'h8000_0040,
    parameter logic [XLEN-1:0] IRQ_VEC     = 32'h8000_0080
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sel,
    input  logic [IMM_W-1:0] imm,
    input  logic [JF_W-1:0]  jfield,
    input  logic [XLEN-1:0]  reg_val,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  pc_plus4
);
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] branch_pc;
    logic [XLEN-1:0] jump_pc;
    logic [XLEN-1:0] next_pc;

    pc_target_gen #(
        .XLEN (XLEN),
        .IMM_W(IMM_W),
        .JF_W (JF_W)
    ) u_targets (
        .cur_pc   (pc_q),
        .imm      (imm),
        .jfield   (jfield),
        .seq_pc   (seq_pc),
        .branch_pc(branch_pc),
        .jump_pc  (jump_pc)
    );

    pc_next_mux #(
        .XLEN       (XLEN),
        .POWERUP_VEC(POWERUP_VEC),
        .BADOP_VEC  (BADOP_VEC),
        .IRQ_VEC    (IRQ_VEC)
    ) u_select (
        .sel      (sel),
        .seq_pc   (seq_pc),
        .branch_pc(branch_pc),
        .jump_pc  (jump_pc),
        .reg_val  (reg_val),
        .next_pc  (next_pc)
    );

    // loads every edge: no hold path by design
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= POWERUP_VEC;
        end else begin
            pc_q <= next_pc;
        end
    end

    assign pc       = pc_q;
    assign pc_plus4 = seq_pc;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int              XLEN        = 32,
    parameter int              IMM_W       = 16,
    parameter int              JF_W        = 26,
    parameter logic [XLEN-1:0] POWERUP_VEC = 32'h8000_0000,
    parameter logic [XLEN-1:0] BADOP_VEC   = 32'h8000_0040,
    parameter logic [XLEN-1:0] IRQ_VEC     = 32'h8000_0080
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sel,
    input logic [IMM_W-1:0] imm,
    input logic [JF_W-1:0]  jfield,
    input logic [XLEN-1:0]  reg_val,
    input logic [XLEN-1:0]  pc,
    input logic [XLEN-1:0]  pc_plus4
);
    localparam int EXT_W = XLEN - IMM_W - 2;
    localparam int UP_W  = XLEN - JF_W - 2;
    localparam logic [XLEN-1:0] FOUR = XLEN'(4);

    assert_plus4_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_plus4 == pc + FOUR);

    assert_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 3'd0 |=> pc == $past(pc) + FOUR);

    assert_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 3'd1 |=> pc == $past(pc) + FOUR
                          + {{EXT_W{$past(imm[IMM_W-1])}}, $past(imm), 2'b00});

    assert_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 3'd2 |=> pc == {$past(pc_plus4[XLEN-1 -: UP_W]), $past(jfield), 2'b00});

    assert_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 3'd3 |=> pc == $past(reg_val));

    assert_powerup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 3'd4 |=> pc == POWERUP_VEC);

    assert_badop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 3'd5 |=> pc == BADOP_VEC);

    assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 3'd6 |=> pc == IRQ_VEC);

    assert_spare_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 3'd7 |=> pc == $past(pc_plus4));
endmodule

bind pc_sequencer pc_sequencer_chk #(
    .XLEN       (XLEN),
    .IMM_W      (IMM_W),
    .JF_W       (JF_W),
    .POWERUP_VEC(POWERUP_VEC),
    .BADOP_VEC  (BADOP_VEC),
    .IRQ_VEC    (IRQ_VEC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .imm     (imm),
    .jfield  (jfield),
    .reg_val (reg_val),
    .pc      (pc),
    .pc_plus4(pc_plus4)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] imm;
        logic [25:0] jf;
        logic [31:0] rv;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 16'h0000, 26'h0000000, 32'h0000_0000},
        '{3'd1, 16'h0010, 26'h0000000, 32'h0000_0000},
        '{3'd1, 16'hFFFF, 26'h0000000, 32'h0000_0000},
        '{3'd2, 16'h0000, 26'h3FFFFFF, 32'h0000_0000},
        '{3'd3, 16'h0000, 26'h0000000, 32'h0000_1233},
        '{3'd0, 16'h0000, 26'h0000000, 32'h0000_0000},
        '{3'd1, 16'h8000, 26'h0000000, 32'h0000_0000},
        '{3'd5, 16'h1234, 26'h1234567, 32'h1111_1111},
        '{3'd7, 16'h0000, 26'h0000000, 32'h0000_0000},
        '{3'd6, 16'h0000, 26'h0000000, 32'h0000_0000},
        '{3'd4, 16'h0000, 26'h0000000, 32'h0000_0000},
        '{3'd3, 16'h0000, 26'h0000000, 32'hFFFF_FFFC},
        '{3'd0, 16'h0000, 26'h0000000, 32'h0000_0000},
        '{3'd3, 16'h0000, 26'h0000000, 32'hEFFF_FFFC},
        '{3'd2, 16'h0000, 26'h0000001, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  sel;
    logic [15:0] imm;
    logic [25:0] jfield;
    logic [31:0] reg_val;
    logic [31:0] pc;
    logic [31:0] pc_plus4;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] model;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pc_sequencer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .imm     (imm),
        .jfield  (jfield),
        .reg_val (reg_val),
        .pc      (pc),
        .pc_plus4(pc_plus4)
    );

    function automatic logic [31:0] predict(logic [31:0] cur, vec_t v);
        logic [31:0] inc;
        inc = cur + 32'd4;
        case (v.sel)
            3'd1:    return inc + {{14{v.imm[15]}}, v.imm, 2'b00};
            3'd2:    return {inc[31:28], v.jf, 2'b00};
            3'd3:    return v.rv;
            3'd4:    return 32'h8000_0000;
            3'd5:    return 32'h8000_0040;
            3'd6:    return 32'h8000_0080;
            default: return inc;
        endcase
    endfunction

    function automatic string req_of(logic [2:0] s);
        case (s)
            3'd0:    return "R3/R9";
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            3'd7:    return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(vec_t v);
        sel     = v.sel;
        imm     = v.imm;
        jfield  = v.jf;
        reg_val = v.rv;
        model   = predict(model, v);
        @(negedge clk);
        check(req_of(v.sel), pc, model);
        check("R2", pc_plus4, model + 32'd4);
    endtask

    initial begin
        rst_n = 1'b0; sel = 3'd0; imm = '0; jfield = '0; reg_val = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1", pc, 32'h8000_0000);
        check("R2", pc_plus4, 32'h8000_0004);
        rst_n = 1'b1;
        model = 32'h8000_0000;

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i]);
        end

        // R1: reset wins over a register jump
        rst_n = 1'b0; sel = 3'd3; reg_val = 32'h0000_1234;
        @(negedge clk);
        check("R1", pc, 32'h8000_0000);
        rst_n = 1'b1;
        model = 32'h8000_0000;

        // R9: sequential run, new value every edge
        for (int k = 0; k < 5; k++) begin
            step('{3'd0, 16'h0, 26'h0, 32'h0});
        end
        check("R9", pc, 32'h8000_0014);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule